// File: doc/BRIEF.md
# Single-Phase Soft-Switching Commutator

This block turns a synchronised Hall phase bit and a per-cycle PWM drive/regenerate decision into the four gate enables of a single-phase H-bridge, plus a rotation output. The Hall phase picks which leg is switched by PWM and which leg holds its low side on. Each Hall half-period is timed in clock cycles. The previous half-period then predicts where the next phase change will fall.

Around each predicted change the block shapes the drive softly. The soft window is three sixteenths of the previous half-period. Over that window the allowed drive time of each PWM pulse steps down through eighths to zero at the predicted change. After a real change, the block first forces a fixed regenerate gap. It then climbs back through eighths to the full commanded pulse. A lock-protection input can remove all high-side drive while the low sides keep commutating. Each leg has its own dead-time sequencer, so the two switches of a leg never conduct together.

Top module: `soft_comm`

## Requirements
- R1: With the Hall phase at 1, leg 1 is the PWM leg and leg 2 keeps its low side on; with phase 0 the roles swap. The PWM leg turns its high side on while the drive decision is 1 and its low side on while it is 0.
- R2: While hs_enable is 0, both high-side enables are 0 from the next cycle on, and the low-side enables behave as with hs_enable at 1.
- R3: fg equals the Hall input delayed by two clock cycles, so it toggles once per phase change.
- R4: A leg never has both enables at 1, and a high or low enable can only rise after a sampled cycle in which the opposite enable of that leg was 0 (at least one cycle of dead time).
- R5: During reset all five outputs are 0.
- R6: The half-period counter saturates at its maximum. Until the second Hall change after reset, drive is hard-switched: full commanded pulses, no gap and no ramps.
- R7: After every later phase change, the new PWM leg keeps its high side off for GAP_CYC cycles (forced regenerate).
- R8: After the gap, the allowed drive time climbs in eighths of the previous drive-pulse length, one eighth per step, until full. A step lasts one eighth of the window, and the window is 3/16 of the previous half-period.
- R9: From (previous half-period minus window) cycles after a change, the allowed drive time falls by one eighth per step. It reaches zero for the last step before the predicted change and stays at zero until the change.
- R10: A Hall change that arrives while the falling ramp is still running ends that ramp at once and starts the regenerate gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 1 | Hall phase bit, already synchronised |
| pwm_drive | input | 1 | 1 = drive, 0 = regenerate for this PWM instant |
| hs_enable | input | 1 | 0 removes all high-side drive (lock protection) |
| leg1_hi | output | 1 | Leg 1 high-side enable |
| leg1_lo | output | 1 | Leg 1 low-side enable |
| leg2_hi | output | 1 | Leg 2 high-side enable |
| leg2_lo | output | 1 | Leg 2 low-side enable |
| fg | output | 1 | Rotation output, follows the Hall phase |

## Verification
The falling ramp and a phase change can land on the same cycle when the rotor speeds up, and the dead-time handover on both legs happens in that cycle too. The bench provokes this by toggling the Hall bit at about 85% of the previous half-period, while the ramp still allows drive. It then expects both high sides to stay off through the forced gap, and drive to return later on the new leg. A cycle-by-cycle monitor watches every leg for overlap and for an enable rising straight out of its opposite enable, across all the PWM transitions of the run.

// File: rtl/soft_comm_pkg.sv
package soft_comm_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_cmd_e;

  typedef enum logic [2:0] {
    TP_HARD = 3'd0,
    TP_GAP  = 3'd1,
    TP_RISE = 3'd2,
    TP_RUN  = 3'd3,
    TP_FALL = 3'd4
  } taper_st_e;

  localparam int unsigned LVL_W = 4;
  localparam logic [LVL_W-1:0] LVL_FULL = 4'd8;
  localparam logic [LVL_W-1:0] LVL_TOP  = 4'd7;

endpackage

// File: rtl/hall_timer.sv
module hall_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hall_in,
  output logic             phase,
  output logic             edge_p,
  output logic             seen,
  output logic [CNT_W-1:0] elapsed,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic hall_s;

  // phase change detected one cycle after sampling
  assign edge_p = hall_s ^ phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      hall_s  <= 1'b0;
      phase   <= 1'b0;
      elapsed <= '0;
      period  <= '0;
      seen    <= 1'b0;
    end else begin
      hall_s <= hall_in;
      if (edge_p) begin
        phase   <= hall_s;
        period  <= elapsed;
        elapsed <= '0;
        seen    <= 1'b1;
      end else if (elapsed != CNT_MAX) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

endmodule

// File: rtl/taper_seq.sv
module taper_seq
  import soft_comm_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned GAP_CYC = 75000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_p,
  input  logic             seen,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [CNT_W-1:0] period,
  output logic [LVL_W-1:0] level
);

  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  taper_st_e        st;
  logic [CNT_W-1:0] sub;
  logic [GAP_W-1:0] gap_cnt;

  logic [CNT_W+1:0] prod3;
  logic [CNT_W-1:0] window;
  logic [CNT_W-1:0] step_raw;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] fall_start;
  logic             step_done;

  // window = 3/16 of the half-period, step = 1/8 of the window
  always_comb begin
    prod3      = {2'b00, period} + {1'b0, period, 1'b0};
    window     = CNT_W'(prod3 >> 4);
    step_raw   = window >> 3;
    step       = (step_raw == '0) ? CNT_W'(1) : step_raw;
    fall_start = period - window;
    step_done  = (sub == step - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TP_HARD;
      level   <= LVL_FULL;
      sub     <= '0;
      gap_cnt <= '0;
    end else if (edge_p) begin
      sub     <= '0;
      gap_cnt <= '0;
      if (seen) begin
        st    <= TP_GAP;
        level <= '0;
      end else begin
        st    <= TP_HARD;
        level <= LVL_FULL;
      end
    end else begin
      unique case (st)
        TP_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            st    <= TP_RISE;
            level <= 4'd1;
            sub   <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        TP_RISE, TP_RUN: begin
          if (elapsed >= fall_start) begin
            st    <= TP_FALL;
            sub   <= '0;
            level <= (level == '0) ? '0 : level - 1'b1;
          end else if (st == TP_RISE) begin
            if (step_done) begin
              sub <= '0;
              if (level >= LVL_TOP) begin
                level <= LVL_FULL;
                st    <= TP_RUN;
              end else begin
                level <= level + 1'b1;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
        TP_FALL: begin
          if (step_done) begin
            sub <= '0;
            if (level != '0) level <= level - 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: level <= LVL_FULL;
      endcase
    end
  end

endmodule

// File: rtl/duty_gate.sv
module duty_gate
  import soft_comm_pkg::*;
#(
  parameter int unsigned PW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_drive,
  input  logic [LVL_W-1:0] level,
  output logic             drive
);

  localparam logic [PW_W-1:0] PW_MAX = '1;

  logic [PW_W-1:0]   pulse_cnt;
  logic [PW_W-1:0]   hi_len;
  logic [PW_W+3:0]   prod;
  logic [PW_W-1:0]   lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_cnt <= '0;
      hi_len    <= '0;
    end else if (pwm_drive) begin
      if (pulse_cnt != PW_MAX) pulse_cnt <= pulse_cnt + 1'b1;
    end else begin
      if (pulse_cnt != '0) hi_len <= pulse_cnt;
      pulse_cnt <= '0;
    end
  end

  // allowed drive cycles = previous pulse length * level / 8
  always_comb begin
    prod  = (PW_W + 4)'(hi_len) * (PW_W + 4)'(level);
    lim   = PW_W'(prod >> 3);
    drive = pwm_drive & ((level >= LVL_FULL) | (pulse_cnt < lim));
  end

endmodule

// File: rtl/leg_driver.sv
module leg_driver
  import soft_comm_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  leg_cmd_e cmd,
  output logic     hi,
  output logic     lo
);

  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LIM = DW'(DEAD_CYC);

  logic [DW-1:0] off_cnt;
  logic          off_ok;

  assign off_ok = (off_cnt == DEAD_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      off_cnt <= '0;
    end else begin
      if (hi | lo) off_cnt <= '0;
      else if (!off_ok) off_cnt <= off_cnt + 1'b1;
      unique case (cmd)
        LEG_HI: begin
          lo <= 1'b0;
          hi <= hi | (!lo & off_ok);
        end
        LEG_LO: begin
          hi <= 1'b0;
          lo <= lo | (!hi & off_ok);
        end
        default: begin
          hi <= 1'b0;
          lo <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/soft_comm.sv
module soft_comm
  import soft_comm_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned GAP_CYC  = 75000,
  parameter int unsigned DEAD_CYC = 2,
  parameter int unsigned PW_W     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic hall_in,
  input  logic pwm_drive,
  input  logic hs_enable,
  output logic leg1_hi,
  output logic leg1_lo,
  output logic leg2_hi,
  output logic leg2_lo,
  output logic fg
);

  localparam int unsigned NLEG = 2;

  logic             phase;
  logic             edge_p;
  logic             seen;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] period;
  logic [LVL_W-1:0] level;
  logic             drive;
  leg_cmd_e         pwm_cmd;
  leg_cmd_e         cmd [NLEG];
  logic             leg_hi [NLEG];
  logic             leg_lo [NLEG];

  hall_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hall_in (hall_in),
    .phase   (phase),
    .edge_p  (edge_p),
    .seen    (seen),
    .elapsed (elapsed),
    .period  (period)
  );

  taper_seq #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_taper (
    .clk     (clk),
    .rst     (rst),
    .edge_p  (edge_p),
    .seen    (seen),
    .elapsed (elapsed),
    .period  (period),
    .level   (level)
  );

  duty_gate #(.PW_W(PW_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .pwm_drive (pwm_drive),
    .level     (level),
    .drive     (drive)
  );

  always_comb begin
    if (!drive)         pwm_cmd = LEG_LO;
    else if (hs_enable) pwm_cmd = LEG_HI;
    else                pwm_cmd = LEG_OFF;
    cmd[0] = phase ? pwm_cmd : LEG_LO;
    cmd[1] = phase ? LEG_LO  : pwm_cmd;
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_driver #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk (clk),
      .rst (rst),
      .cmd (cmd[g]),
      .hi  (leg_hi[g]),
      .lo  (leg_lo[g])
    );
  end

  assign leg1_hi = leg_hi[0];
  assign leg1_lo = leg_lo[0];
  assign leg2_hi = leg_hi[1];
  assign leg2_lo = leg_lo[1];
  assign fg      = phase;

endmodule

// File: rtl/soft_comm_chk.sv
module soft_comm_chk (
  input logic clk,
  input logic rst,
  input logic hall_in,
  input logic hs_enable,
  input logic leg1_hi,
  input logic leg1_lo,
  input logic leg2_hi,
  input logic leg2_lo,
  input logic fg
);

  logic [1:0] rdy;

  always_ff @(posedge clk) begin
    if (rst) rdy <= 2'd0;
    else if (rdy != 2'd3) rdy <= rdy + 2'd1;
  end

  p_leg1_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(leg1_hi && leg1_lo));
  p_leg2_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(leg2_hi && leg2_lo));
  p_leg1_dead_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg1_hi) |-> !$past(leg1_lo));
  p_leg2_dead_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg2_lo) |-> !$past(leg2_hi));
  p_hs_off_r2: assert property (@(posedge clk) disable iff (rst)
    !hs_enable |=> (!leg1_hi && !leg2_hi));
  p_leg2_role_r1: assert property (@(posedge clk) disable iff (rst)
    $past(fg) |-> !leg2_hi);
  p_leg1_role_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(fg) |-> !leg1_hi);
  p_fg_track_r3: assert property (@(posedge clk) disable iff (rst)
    (rdy == 2'd3) |-> (fg == $past(hall_in, 2)));

endmodule

bind soft_comm soft_comm_chk u_chk (.*);

// File: tb/soft_comm_tb.sv
`timescale 1ns/1ps
module soft_comm_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hall_in = 1'b0;
  logic pwm_drive = 1'b0;
  logic hs_enable = 1'b1;
  logic leg1_hi, leg1_lo, leg2_hi, leg2_lo, fg;

  logic pwm_auto = 1'b0;
  logic pwm_man = 1'b0;
  int   pwm_ph = 0;
  int   checks = 0;
  int   errors = 0;
  int   dt_bad = 0;
  int   dt_rise = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  soft_comm #(.CNT_W(16), .GAP_CYC(40), .DEAD_CYC(1), .PW_W(8)) u_dut (
    .clk (clk), .rst (rst), .hall_in (hall_in), .pwm_drive (pwm_drive),
    .hs_enable (hs_enable), .leg1_hi (leg1_hi), .leg1_lo (leg1_lo),
    .leg2_hi (leg2_hi), .leg2_lo (leg2_lo), .fg (fg)
  );

  // {hall, pwm, hs, leg1_hi, leg1_lo, leg2_hi, leg2_lo, fg}
  localparam logic [7:0] VEC [0:7] = '{
    8'b111_10011, 8'b101_01011, 8'b110_00011, 8'b100_01011,
    8'b011_01100, 8'b001_01010, 8'b010_01000, 8'b000_01010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input bit ok, input int act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %s", req, act, exp);
    end
  endtask

  task automatic count_hi(input int leg, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (leg != 2) c += int'(leg1_hi);
      if (leg != 1) c += int'(leg2_hi);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
  endtask

  // PWM source: 16-cycle period, 8 cycles drive
  initial begin
    forever begin
      @(negedge clk);
      if (pwm_auto) begin
        pwm_ph = (pwm_ph + 1) % 16;
        pwm_drive = (pwm_ph < 8);
      end else begin
        pwm_drive = pwm_man;
      end
    end
  end

  // dead-time monitor for R4
  initial begin
    logic p1h, p1l, p2h, p2l;
    p1h = 0; p1l = 0; p2h = 0; p2l = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if ((leg1_hi && leg1_lo) || (leg2_hi && leg2_lo)) dt_bad++;
        if ((leg1_hi && !p1h && p1l) || (leg1_lo && !p1l && p1h)) dt_bad++;
        if ((leg2_hi && !p2h && p2l) || (leg2_lo && !p2l && p2h)) dt_bad++;
        if ((leg1_hi && !p1h) || (leg2_hi && !p2h)) dt_rise++;
      end
      p1h = leg1_hi; p1l = leg1_lo; p2h = leg2_hi; p2l = leg2_lo;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c_a, c_b, rise_c, run_c, fall_a, fall_b;
    logic [4:0] got;

    // R5: reset state
    tick(3);
    got = {leg1_hi, leg1_lo, leg2_hi, leg2_lo, fg};
    check("R5 reset outputs", got == 5'b0, int'(got), "0");

    // table walk: R1 roles, R2 high-side disable, R3 fg level (hard mode, R6)
    for (int i = 0; i < 8; i++) begin
      rst = 1'b1;
      hall_in = VEC[i][7];
      pwm_man = VEC[i][6];
      hs_enable = VEC[i][5];
      tick(3);
      rst = 1'b0;
      tick(12);
      got = {leg1_hi, leg1_lo, leg2_hi, leg2_lo, fg};
      check($sformatf("R1/R2/R3 vector %0d", i), got == VEC[i][4:0], int'(got),
            $sformatf("%0d", VEC[i][4:0]));
    end

    // directed: soft switching sequence
    hall_in = 1'b0;
    hs_enable = 1'b1;
    pwm_auto = 1'b1;
    do_reset();
    tick(50);

    // first change after reset: hard switching, no gap (R6)
    hall_in = 1'b1;
    tick(3);
    count_hi(1, 30, c_a);
    check("R6 no gap before second change", c_a > 0, c_a, ">0");
    tick(2048 - 33);

    // second change: gap then rise
    hall_in = 1'b0;
    tick(3);
    count_hi(3, 27, c_a);
    check("R7 forced regenerate gap", c_a == 0, c_a, "0");
    count_hi(2, 354, rise_c);
    tick(600 - 384);
    count_hi(2, 384, run_c);
    check("R8 full duty after rise", run_c >= 100, run_c, ">=100");
    check("R8 rising ramp below full", rise_c < run_c && rise_c > 0, rise_c, "between 0 and run");
    tick(1664 - 984);
    count_hi(2, 344, fall_a);
    count_hi(2, 40, fall_b);
    check("R9 falling ramp below full", fall_a < run_c && fall_a > 0, fall_a, "between 0 and run");
    check("R9 zero duty before change", fall_b == 0, fall_b, "0");

    // third change, then an early change during the falling ramp
    hall_in = 1'b1;
    tick(1);
    check("R3 fg after one cycle", fg == 1'b0, int'(fg), "0");
    tick(1);
    check("R3 fg after two cycles", fg == 1'b1, int'(fg), "1");
    tick(1700 - 2);
    count_hi(1, 50, c_b);
    check("R9 ramp still driving early", c_b > 0, c_b, ">0");
    hall_in = 1'b0;
    tick(3);
    count_hi(3, 27, c_a);
    check("R10 early change enters gap", c_a == 0, c_a, "0");
    tick(600 - 30);
    count_hi(2, 384, c_a);
    check("R10 drive resumes on new leg", c_a > 0, c_a, ">0");

    // R2 with automatic PWM: high sides stay off
    hs_enable = 1'b0;
    tick(2);
    count_hi(3, 64, c_a);
    check("R2 high sides off", c_a == 0, c_a, "0");
    hs_enable = 1'b1;
    tick(20);

    check("R4 no overlap or direct handover", dt_bad == 0, dt_bad, "0");
    check("R4 high-side turn-ons observed", dt_rise > 0, dt_rise, ">0");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule